// File: doc/BRIEF.md
# Code Memory Protection Gate

This block sits between the instruction sequencer, the programming port and an on-chip code memory. It reads three non-volatile protection bits and turns them into a protection level. Four kinds of request arrive each cycle:

- a code fetch with its address;
- a table read issued by code running from external memory that targets the internal array;
- a byte-programming request;
- a readback-verify request.

For every request that is present, the block answers with exactly one grant or one deny in the following cycle.

The block also resolves the external-access strap. When the first protection bit is clear, the live pin level is used. When that bit is set, the level captured while reset was held is used instead, and it stays fixed until the next reset. The resolved level decides whether a fetch goes to the internal array or to the external bus. A low level sends every address in the 16-bit space to the external bus. A high level sends addresses below the internal array size to the internal array and all other addresses to the external bus.

All outputs are registered, so a request presented in cycle N is answered in cycle N+1.

Top module: `pmem_lock_ctrl`

## Requirements
- R1: `prot_level` reports the highest level implied by any set bit. `lock_prog[0]` implies level 1, `lock_prog[1]` implies level 2 and `lock_prog[2]` implies level 3. With no bit set the level is 0. A set bit means the bit is programmed.
- R2: At level 0, every present request is granted.
- R3: `movc_req` is denied whenever the level is 1 or higher, and granted otherwise.
- R4: `prog_req` is denied whenever the level is 1 or higher, and granted otherwise.
- R5: `verify_req` is denied whenever the level is 2 or higher, and granted otherwise.
- R6: A fetch routed to the external bus is denied at level 3, and granted below level 3. Fetches routed to the internal array are always granted.
- R7: When `lock_prog[0]` is set, the resolved strap level equals the `ea_pin` value sampled at the last clock edge with `rst_n` low. Later pin changes have no effect on it until the next reset. A pin change in the same cycle that reset is released is not captured.
- R8: When `lock_prog[0]` is clear, `ea_level` equals the `ea_pin` value of the previous cycle.
- R9: A fetch is routed internally only when the resolved level is 1 and `fetch_addr` is below `INT_DEPTH` (4096). Otherwise it is routed externally.
- R10: For each request, at most one of its grant or deny outputs is high. All of them are low one cycle after the request is absent.
- R11: At a clock edge with `rst_n` low, all grant, deny, `ea_level` and `prot_level` outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while it is low |
| lock_prog | input | 3 | Protection bits, 1 = programmed |
| ea_pin | input | 1 | External-access strap pin, low = external execution |
| fetch_req | input | 1 | Code fetch request |
| fetch_addr | input | 16 | Code fetch address |
| movc_req | input | 1 | Table read from external code into the internal array |
| prog_req | input | 1 | Byte-programming request |
| verify_req | input | 1 | Readback-verify request |
| fetch_int_gnt | output | 1 | Fetch granted from the internal array |
| fetch_ext_gnt | output | 1 | Fetch granted on the external bus |
| fetch_deny | output | 1 | Fetch refused |
| movc_gnt | output | 1 | Table read granted |
| movc_deny | output | 1 | Table read refused |
| prog_gnt | output | 1 | Programming granted |
| prog_deny | output | 1 | Programming refused |
| verify_gnt | output | 1 | Verify granted |
| verify_deny | output | 1 | Verify refused |
| ea_level | output | 1 | Resolved external-access level |
| prot_level | output | 2 | Decoded protection level |

## Verification
Two functions can fall in the same cycle: the strap capture that ends when reset is released, and the first fetch routing decision that depends on the captured value. The bench provokes this by releasing reset in the same cycle that it flips the pin and issues a fetch to address 0 with the first protection bit set. It then judges that the fetch goes to the internal array using the pre-release pin level, and that this stays true in the following cycle. A second collision happens when a protection-bit change arrives together with a live pin value. The exhaustive sweep covers it by checking both pin levels against every bit pattern, for each captured strap value.

// File: rtl/pmlock_pkg.sv
// pmlock_pkg: shared level encoding and per-request deny thresholds for the
// code memory protection gate. Assumes exactly three protection bits.
package pmlock_pkg;

    localparam int LOCK_BITS = 3;
    localparam int NUM_GATED = 3;
    localparam int GATE_MOVC   = 0;
    localparam int GATE_PROG   = 1;
    localparam int GATE_VERIFY = 2;

    typedef enum logic [1:0] {
        PROT_OPEN        = 2'd0,
        PROT_NO_WRITE    = 2'd1,
        PROT_NO_READBACK = 2'd2,
        PROT_NO_EXTERNAL = 2'd3
    } prot_e;

    typedef struct packed {
        logic int_gnt;
        logic ext_gnt;
        logic deny;
    } fetch_res_t;

    // Lowest level at which a gated request class is refused.
    function automatic prot_e gate_floor(input int idx);
        case (idx)
            GATE_MOVC:   return PROT_NO_WRITE;
            GATE_PROG:   return PROT_NO_WRITE;
            default:     return PROT_NO_READBACK;
        endcase
    endfunction

endpackage

// File: rtl/pmlock_level_dec.sv
// pmlock_level_dec: folds the protection bits into one cumulative level.
// Bit i set implies level i+1; the highest implied level wins, so irregular
// patterns still get the strongest protection any set bit asks for.
module pmlock_level_dec
    import pmlock_pkg::*;
(
    input  logic [LOCK_BITS-1:0] lock_prog,
    output prot_e                level
);

    logic [1:0] lvl_raw;

    // Scan bits upward; a higher set bit overrides a lower one.
    always_comb begin
        lvl_raw = 2'd0;
        for (int i = 0; i < LOCK_BITS; i++) begin
            if (lock_prog[i]) lvl_raw = 2'(i + 1);
        end
    end

    assign level = prot_e'(lvl_raw);

endmodule

// File: rtl/pmlock_ea_capture.sv
// pmlock_ea_capture: samples the external-access strap on every edge while
// reset is held, then freezes. The held value has no power-up value (it is
// unknown until the first reset). latch_mode selects held or live level.
module pmlock_ea_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic ea_pin,
    input  logic latch_mode,
    output logic ea_eff
);

    logic ea_hold;

    // Track the pin only during reset; hold once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) ea_hold <= ea_pin;
    end

    assign ea_eff = latch_mode ? ea_hold : ea_pin;

endmodule

// File: rtl/pmlock_fetch_route.sv
// pmlock_fetch_route: decides whether a fetch uses the internal array or the
// external bus, and refuses external fetches at the top level. Assumes
// INT_DEPTH is at most 2**ADDR_W.
module pmlock_fetch_route
    import pmlock_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int INT_DEPTH = 4096
) (
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              ea_eff,
    input  prot_e             level,
    output fetch_res_t        res
);

    localparam logic [ADDR_W:0] SPACE = {1'b1, {ADDR_W{1'b0}}};

    logic beyond_int;

    generate
        if (INT_DEPTH >= SPACE) begin : g_full
            assign beyond_int = 1'b0;
        end else begin : g_part
            assign beyond_int = (fetch_addr >= ADDR_W'(INT_DEPTH));
        end
    endgenerate

    logic go_ext;
    assign go_ext = !ea_eff || beyond_int;

    // Pick exactly one response for a present fetch.
    always_comb begin
        res = '0;
        if (fetch_req) begin
            if (!go_ext)                     res.int_gnt = 1'b1;
            else if (level == PROT_NO_EXTERNAL) res.deny = 1'b1;
            else                             res.ext_gnt = 1'b1;
        end
    end

endmodule

// File: rtl/pmlock_access_gate.sv
// pmlock_access_gate: grants or refuses one request class by comparing the
// current level with the class threshold FLOOR.
module pmlock_access_gate
    import pmlock_pkg::*;
#(
    parameter prot_e FLOOR = PROT_NO_WRITE
) (
    input  logic  req,
    input  prot_e level,
    output logic  gnt,
    output logic  deny
);

    logic blocked;
    assign blocked = (level >= FLOOR);

    // One of grant or deny, only when requested.
    assign deny = req && blocked;
    assign gnt  = req && !blocked;

endmodule

// File: rtl/pmem_lock_ctrl.sv
// pmem_lock_ctrl: top of the code memory protection gate. Decodes the
// protection level, resolves the strap, routes fetches and gates table read,
// programming and verify. All responses are registered (one cycle latency)
// and cleared by synchronous active-low reset.
module pmem_lock_ctrl
    import pmlock_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int INT_DEPTH = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LOCK_BITS-1:0] lock_prog,
    input  logic                 ea_pin,
    input  logic                 fetch_req,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 movc_req,
    input  logic                 prog_req,
    input  logic                 verify_req,
    output logic                 fetch_int_gnt,
    output logic                 fetch_ext_gnt,
    output logic                 fetch_deny,
    output logic                 movc_gnt,
    output logic                 movc_deny,
    output logic                 prog_gnt,
    output logic                 prog_deny,
    output logic                 verify_gnt,
    output logic                 verify_deny,
    output logic                 ea_level,
    output logic [1:0]           prot_level
);

    prot_e      level;
    logic       ea_eff;
    fetch_res_t fres;

    logic [NUM_GATED-1:0] g_req;
    logic [NUM_GATED-1:0] g_gnt;
    logic [NUM_GATED-1:0] g_deny;

    pmlock_level_dec u_dec (
        .lock_prog (lock_prog),
        .level     (level)
    );

    pmlock_ea_capture u_ea (
        .clk        (clk),
        .rst_n      (rst_n),
        .ea_pin     (ea_pin),
        .latch_mode (lock_prog[0]),
        .ea_eff     (ea_eff)
    );

    pmlock_fetch_route #(
        .ADDR_W    (ADDR_W),
        .INT_DEPTH (INT_DEPTH)
    ) u_route (
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .ea_eff     (ea_eff),
        .level      (level),
        .res        (fres)
    );

    assign g_req[GATE_MOVC]   = movc_req;
    assign g_req[GATE_PROG]   = prog_req;
    assign g_req[GATE_VERIFY] = verify_req;

    generate
        for (genvar g = 0; g < NUM_GATED; g++) begin : g_gate
            pmlock_access_gate #(
                .FLOOR (gate_floor(g))
            ) u_gate (
                .req   (g_req[g]),
                .level (level),
                .gnt   (g_gnt[g]),
                .deny  (g_deny[g])
            );
        end
    endgenerate

    // Register every response; clear all of them during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_int_gnt <= 1'b0;
            fetch_ext_gnt <= 1'b0;
            fetch_deny    <= 1'b0;
            movc_gnt      <= 1'b0;
            movc_deny     <= 1'b0;
            prog_gnt      <= 1'b0;
            prog_deny     <= 1'b0;
            verify_gnt    <= 1'b0;
            verify_deny   <= 1'b0;
            ea_level      <= 1'b0;
            prot_level    <= 2'd0;
        end else begin
            fetch_int_gnt <= fres.int_gnt;
            fetch_ext_gnt <= fres.ext_gnt;
            fetch_deny    <= fres.deny;
            movc_gnt      <= g_gnt[GATE_MOVC];
            movc_deny     <= g_deny[GATE_MOVC];
            prog_gnt      <= g_gnt[GATE_PROG];
            prog_deny     <= g_deny[GATE_PROG];
            verify_gnt    <= g_gnt[GATE_VERIFY];
            verify_deny   <= g_deny[GATE_VERIFY];
            ea_level      <= ea_eff;
            prot_level    <= level;
        end
    end

endmodule

// File: rtl/pmem_lock_ctrl_chk.sv
// pmem_lock_ctrl_chk: temporal checks on the protection gate ports, bound
// into every pmem_lock_ctrl instance.
module pmem_lock_ctrl_chk #(
    parameter int ADDR_W    = 16,
    parameter int INT_DEPTH = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        lock_prog,
    input logic              ea_pin,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              movc_req,
    input logic              prog_req,
    input logic              verify_req,
    input logic              fetch_int_gnt,
    input logic              fetch_ext_gnt,
    input logic              fetch_deny,
    input logic              movc_gnt,
    input logic              movc_deny,
    input logic              prog_gnt,
    input logic              prog_deny,
    input logic              verify_gnt,
    input logic              verify_deny,
    input logic              ea_level,
    input logic [1:0]        prot_level
);

    logic addr_high;
    assign addr_high = ({1'b0, fetch_addr} >= (ADDR_W+1)'(INT_DEPTH));

    a_r1_top_bit_level: assert property (@(posedge clk) disable iff (!rst_n)
        lock_prog[2] |=> prot_level == 2'd3);

    a_r3_movc_refused: assert property (@(posedge clk) disable iff (!rst_n)
        movc_req && lock_prog != 3'b000 |=> movc_deny && !movc_gnt);

    a_r4_prog_refused: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req && lock_prog != 3'b000 |=> prog_deny && !prog_gnt);

    a_r5_verify_refused: assert property (@(posedge clk) disable iff (!rst_n)
        verify_req && lock_prog[2:1] != 2'b00 |=> verify_deny && !verify_gnt);

    a_r6_no_ext_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && lock_prog[2] |=> !fetch_ext_gnt);

    a_r7_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock_prog[0] ##1 lock_prog[0] |=> $stable(ea_level));

    a_r8_strap_live: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_prog[0] |=> ea_level == $past(ea_pin));

    a_r9_high_addr_external: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && addr_high |=> !fetch_int_gnt);

    a_r10_fetch_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> $onehot({fetch_int_gnt, fetch_ext_gnt, fetch_deny}));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req && !movc_req && !prog_req && !verify_req |=>
        !(fetch_int_gnt || fetch_ext_gnt || fetch_deny || movc_gnt || movc_deny
          || prog_gnt || prog_deny || verify_gnt || verify_deny));

    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> ({fetch_int_gnt, fetch_ext_gnt, fetch_deny, movc_gnt, movc_deny,
                     prog_gnt, prog_deny, verify_gnt, verify_deny, ea_level} == 10'd0)
                   && prot_level == 2'd0);

endmodule

bind pmem_lock_ctrl pmem_lock_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .INT_DEPTH (INT_DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lock_prog     (lock_prog),
    .ea_pin        (ea_pin),
    .fetch_req     (fetch_req),
    .fetch_addr    (fetch_addr),
    .movc_req      (movc_req),
    .prog_req      (prog_req),
    .verify_req    (verify_req),
    .fetch_int_gnt (fetch_int_gnt),
    .fetch_ext_gnt (fetch_ext_gnt),
    .fetch_deny    (fetch_deny),
    .movc_gnt      (movc_gnt),
    .movc_deny     (movc_deny),
    .prog_gnt      (prog_gnt),
    .prog_deny     (prog_deny),
    .verify_gnt    (verify_gnt),
    .verify_deny   (verify_deny),
    .ea_level      (ea_level),
    .prot_level    (prot_level)
);

// File: tb/pmem_lock_ctrl_tb.sv
// pmem_lock_ctrl_tb: exhaustive sweep over captured strap, protection bits,
// live pin, request mix and boundary addresses; expectations are computed
// from the requirements.
module pmem_lock_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  lock_prog = 3'b000;
    logic        ea_pin = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = 16'h0000;
    logic        movc_req = 1'b0;
    logic        prog_req = 1'b0;
    logic        verify_req = 1'b0;
    logic        fetch_int_gnt, fetch_ext_gnt, fetch_deny;
    logic        movc_gnt, movc_deny, prog_gnt, prog_deny;
    logic        verify_gnt, verify_deny, ea_level;
    logic [1:0]  prot_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pmem_lock_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock_prog     (lock_prog),
        .ea_pin        (ea_pin),
        .fetch_req     (fetch_req),
        .fetch_addr    (fetch_addr),
        .movc_req      (movc_req),
        .prog_req      (prog_req),
        .verify_req    (verify_req),
        .fetch_int_gnt (fetch_int_gnt),
        .fetch_ext_gnt (fetch_ext_gnt),
        .fetch_deny    (fetch_deny),
        .movc_gnt      (movc_gnt),
        .movc_deny     (movc_deny),
        .prog_gnt      (prog_gnt),
        .prog_deny     (prog_deny),
        .verify_gnt    (verify_gnt),
        .verify_deny   (verify_deny),
        .ea_level      (ea_level),
        .prot_level    (prot_level)
    );

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h (lock=%b pin=%b addr=%h)",
                     tag, got, exp, lock_prog, ea_pin, fetch_addr);
        end
    endtask

    function automatic logic [1:0] exp_level(input logic [2:0] lb);
        return lb[2] ? 2'd3 : lb[1] ? 2'd2 : lb[0] ? 2'd1 : 2'd0;
    endfunction

    function automatic logic [1:0] pair(input logic req, input logic refuse);
        return req ? (refuse ? 2'b01 : 2'b10) : 2'b00;
    endfunction

    task automatic check_vector(input logic cap);
        logic [1:0] lv;
        logic       eff;
        logic       ext;
        logic [2:0] fexp;
        lv  = exp_level(lock_prog);
        eff = lock_prog[0] ? cap : ea_pin;
        ext = !eff || (fetch_addr >= 16'd4096);
        if (!fetch_req)      fexp = 3'b000;
        else if (!ext)       fexp = 3'b100;
        else if (lv == 2'd3) fexp = 3'b001;
        else                 fexp = 3'b010;
        @(negedge clk);
        chk("R1 level", {2'b00, prot_level}, {2'b00, lv});
        chk(lock_prog[0] ? "R7 held strap" : "R8 live strap", {3'b000, ea_level}, {3'b000, eff});
        chk("R3/R10 movc", {2'b00, movc_gnt, movc_deny}, {2'b00, pair(movc_req, lv >= 2'd1)});
        chk("R4/R10 prog", {2'b00, prog_gnt, prog_deny}, {2'b00, pair(prog_req, lv >= 2'd1)});
        chk("R5/R10 verify", {2'b00, verify_gnt, verify_deny}, {2'b00, pair(verify_req, lv >= 2'd2)});
        chk("R6/R9 fetch", {1'b0, fetch_int_gnt, fetch_ext_gnt, fetch_deny}, {1'b0, fexp});
        if (lv == 2'd0 && (movc_req || prog_req || verify_req))
            chk("R2 open grants", {1'b0, movc_deny, prog_deny, verify_deny}, 4'h0);
    endtask

    task automatic do_reset(input logic pin);
        rst_n  = 1'b0;
        ea_pin = pin;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R11: requests active during reset leave all outputs low.
        fetch_req = 1'b1; movc_req = 1'b1; prog_req = 1'b1; verify_req = 1'b1;
        do_reset(1'b1);
        chk("R11 reset resp", {fetch_int_gnt, fetch_ext_gnt, fetch_deny, movc_gnt}, 4'h0);
        chk("R11 reset resp2", {movc_deny, prog_gnt, prog_deny, verify_gnt}, 4'h0);
        chk("R11 reset state", {verify_deny, ea_level, prot_level}, 4'h0);

        for (int cap = 0; cap < 2; cap++) begin
            fetch_req = 1'b0; movc_req = 1'b0; prog_req = 1'b0; verify_req = 1'b0;
            do_reset(cap[0]);
            rst_n = 1'b1;
            for (int lb = 0; lb < 8; lb++) begin
                for (int pin = 0; pin < 2; pin++) begin
                    for (int rq = 0; rq < 16; rq++) begin
                        for (int ai = 0; ai < 4; ai++) begin
                            lock_prog  = lb[2:0];
                            ea_pin     = pin[0];
                            {verify_req, prog_req, movc_req, fetch_req} = rq[3:0];
                            case (ai)
                                0: fetch_addr = 16'h0000;
                                1: fetch_addr = 16'h0FFF;
                                2: fetch_addr = 16'h1000;
                                default: fetch_addr = 16'hFFFF;
                            endcase
                            check_vector(cap[0]);
                        end
                    end
                end
            end
        end

        // R7 collision: reset release, pin flip and fetch in one cycle.
        fetch_req = 1'b0; movc_req = 1'b0; prog_req = 1'b0; verify_req = 1'b0;
        lock_prog = 3'b001;
        do_reset(1'b1);
        rst_n      = 1'b1;
        ea_pin     = 1'b0;
        fetch_req  = 1'b1;
        fetch_addr = 16'h0000;
        @(negedge clk);
        chk("R7 release cycle", {1'b0, ea_level, fetch_int_gnt, fetch_ext_gnt}, 4'b0110);
        @(negedge clk);
        chk("R7 after release", {1'b0, ea_level, fetch_int_gnt, fetch_ext_gnt}, 4'b0110);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule